// File: doc/BRIEF.md
# Texel Prefetch Queue with Reorder Buffer

This block hides memory latency in front of a texel cache. Texel requests enter on a valid/ready input, each with an address, a fragment payload and a flag that marks the last texel of its fragment. The tag of each texel is looked up once, in the cycle it is accepted. A miss sends its memory request in that same cycle, and that request carries a reorder-buffer slot reserved for it. Every accepted texel then waits in an in-order queue that is deep enough to cover the memory round trip.

Memory answers may come back in any order. Each answer echoes its slot number and waits in its slot until the texels that need it reach the head of the queue. The head texel leaves once its data is present. When it leaves, any line fetched on its behalf is written into the cache array. The tag array is updated as soon as a miss is accepted. Later texels to the same line therefore count as hits and share the in-flight slot. A per-slot reference count releases the slot when its last user retires. A per-line pending counter keeps a line from being re-tagged while queued texels still refer to it.

Top module: `texel_prefetch_queue`

## Requirements
- R1: After reset `out_valid` and `mem_req_valid` are low and `in_ready` is high.
- R2: An accepted texel is a hit, and raises no memory request, when its line is valid with a matching tag, including a line whose fetch is still in flight. The line index is `in_addr[IW-1:0]` and the tag is the upper `AW-IW` bits. The tag array is updated at acceptance. `out_hit` reports the result of that single lookup.
- R3: An accepted miss drives `mem_req_valid` in its acceptance cycle. The request carries the texel address and a slot number that has no outstanding request.
- R4: While every reorder slot is reserved, a miss is held off (`in_ready` low) and no further memory request is issued.
- R5: A miss is not accepted while any queued texel still refers to its line index.
- R6: The queue holds up to `QDEPTH` texels. When it is full, `in_ready` is low.
- R7: Texels leave in acceptance order with their payload and last flag. `out_data` equals the memory data for their address, whatever order the answers arrive in.
- R8: While `out_valid` is high and `out_ready` is low, the output stays valid and unchanged.
- R9: A line is written into the cache when its fetching texel retires. Later hits to that line return its data after the slot has been released and reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Texel request valid |
| in_ready | output | 1 | Texel request accepted |
| in_addr | input | AW | Texel line address |
| in_payload | input | PW | Fragment payload carried to the output |
| in_last | input | 1 | Last texel of its fragment |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | AW | Requested line address |
| mem_req_slot | output | SW | Reserved reorder slot |
| mem_rsp_valid | input | 1 | Memory answer valid |
| mem_rsp_slot | input | SW | Slot echoed by the answer |
| mem_rsp_data | input | DW | Line data |
| out_valid | output | 1 | Retired texel valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | DW | Texel data |
| out_payload | output | PW | Fragment payload |
| out_last | output | 1 | Last texel of its fragment |
| out_hit | output | 1 | Texel hit at lookup |

## Verification
Two events can collide in one cycle. A new hit can be accepted on an in-flight line just as that line's first user retires and commits it. The pending counter and the slot reference count then go up and down in the same cycle, and the in-flight mark clears. The bench provokes this with runs of repeated and conflicting addresses under a random `out_ready` and random memory ordering. It judges the outcome by the data of every later hit, and by the absence of any request to a reserved slot or any miss to a referenced line.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
  // Where a queued texel finds its data at retirement.
  typedef enum logic {SRC_LINE = 1'b0, SRC_SLOT = 1'b1} src_e;
endpackage

// File: rtl/tpq_fifo.sv
module tpq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]    mem_q [DEPTH];
  logic [PTRW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= din;
  end

  assign dout  = mem_q[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
endmodule

// File: rtl/tpq_tags.sv
module tpq_tags #(
  parameter int LINES = 8,
  parameter int TW    = 5,
  parameter int DW    = 16,
  parameter int SW    = 2,
  parameter int CW    = 4,
  localparam int IW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] lk_idx,
  input  logic [TW-1:0] lk_tag,
  input  logic          acc,
  input  logic          alloc,
  input  logic [SW-1:0] alloc_slot,
  input  logic          ret,
  input  logic [IW-1:0] ret_idx,
  input  logic          ret_commit,
  input  logic [SW-1:0] ret_slot,
  input  logic [DW-1:0] commit_data,
  output logic          lk_hit,
  output logic          lk_infl,
  output logic [SW-1:0] lk_islot,
  output logic          lk_pend_zero,
  output logic [DW-1:0] rd_data
);
  logic          valid_q [LINES], valid_d [LINES];
  logic [TW-1:0] tag_q   [LINES], tag_d   [LINES];
  logic          infl_q  [LINES], infl_d  [LINES];
  logic [SW-1:0] islot_q [LINES], islot_d [LINES];
  logic [CW-1:0] pend_q  [LINES], pend_d  [LINES];
  logic [DW-1:0] data_q  [LINES];

  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      valid_d[l] = valid_q[l];
      tag_d[l]   = tag_q[l];
      infl_d[l]  = infl_q[l];
      islot_d[l] = islot_q[l];
      pend_d[l]  = pend_q[l] + CW'(acc && (lk_idx == IW'(l)))
                             - CW'(ret && (ret_idx == IW'(l)));
      if (alloc && (lk_idx == IW'(l))) begin
        valid_d[l] = 1'b1;
        tag_d[l]   = lk_tag;
        infl_d[l]  = 1'b1;
        islot_d[l] = alloc_slot;
      end else if (ret_commit && (ret_idx == IW'(l)) && infl_q[l] &&
                   (islot_q[l] == ret_slot)) begin
        infl_d[l]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        valid_q[l] <= 1'b0;
        tag_q[l]   <= '0;
        infl_q[l]  <= 1'b0;
        islot_q[l] <= '0;
        pend_q[l]  <= '0;
      end
    end else begin
      for (int l = 0; l < LINES; l++) begin
        valid_q[l] <= valid_d[l];
        tag_q[l]   <= tag_d[l];
        infl_q[l]  <= infl_d[l];
        islot_q[l] <= islot_d[l];
        pend_q[l]  <= pend_d[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ret_commit) data_q[ret_idx] <= commit_data;
  end

  assign lk_hit       = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_infl      = infl_q[lk_idx];
  assign lk_islot     = islot_q[lk_idx];
  assign lk_pend_zero = (pend_q[lk_idx] == '0);
  assign rd_data      = data_q[ret_idx];
endmodule

// File: rtl/tpq_rob.sv
module tpq_rob #(
  parameter int SLOTS = 4,
  parameter int DW    = 16,
  parameter int CW    = 4,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             share,
  input  logic [SW-1:0]    share_slot,
  input  logic             rel,
  input  logic [SW-1:0]    rel_slot,
  input  logic             rsp_valid,
  input  logic [SW-1:0]    rsp_slot,
  input  logic [DW-1:0]    rsp_data,
  input  logic [SW-1:0]    rd_slot,
  output logic             free_any,
  output logic [SW-1:0]    free_slot,
  output logic [SLOTS-1:0] busy,
  output logic [SLOTS-1:0] ready,
  output logic [DW-1:0]    rd_data
);
  logic [CW-1:0] ref_q [SLOTS], ref_d [SLOTS];
  logic [SLOTS-1:0] rdy_q, rdy_d;
  logic [DW-1:0] data_q [SLOTS];

  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!busy[s]) begin
        free_any  = 1'b1;
        free_slot = SW'(s);
      end
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      busy[s]  = (ref_q[s] != '0);
      ref_d[s] = ref_q[s] + CW'(alloc && (free_slot == SW'(s)))
                          + CW'(share && (share_slot == SW'(s)))
                          - CW'(rel && (rel_slot == SW'(s)));
      rdy_d[s] = (ref_d[s] == '0) ? 1'b0 :
                 (rdy_q[s] || (rsp_valid && (rsp_slot == SW'(s)) && busy[s]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) ref_q[s] <= '0;
      rdy_q <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) ref_q[s] <= ref_d[s];
      rdy_q <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid && busy[rsp_slot]) data_q[rsp_slot] <= rsp_data;
  end

  assign ready   = rdy_q;
  assign rd_data = data_q[rd_slot];
endmodule

// File: rtl/texel_prefetch_queue.sv
module texel_prefetch_queue #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int PW     = 8,
  parameter int LINES  = 8,
  parameter int SLOTS  = 4,
  parameter int QDEPTH = 8,
  localparam int IW    = $clog2(LINES),
  localparam int TW    = AW - IW,
  localparam int SW    = $clog2(SLOTS),
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [PW-1:0] in_payload,
  input  logic          in_last,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  output logic [SW-1:0] mem_req_slot,
  input  logic          mem_rsp_valid,
  input  logic [SW-1:0] mem_rsp_slot,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [PW-1:0] out_payload,
  output logic          out_last,
  output logic          out_hit
);
  import tpq_pkg::*;

  typedef struct packed {
    logic [PW-1:0] payload;
    logic          last;
    logic          hit;
    src_e          src;
    logic [IW-1:0] idx;
    logic [SW-1:0] slot;
  } ent_t;
  localparam int EW = $bits(ent_t);

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic             lk_hit, lk_infl, lk_pend_zero;
  logic [SW-1:0]    lk_islot, free_slot;
  logic             free_any, accept, alloc, share, ret, ret_slot_use;
  logic             q_full, q_empty;
  logic [CW-1:0]    q_count;
  logic [EW-1:0]    head_bits;
  ent_t             new_ent, head;
  logic [SLOTS-1:0] slot_busy, slot_ready;
  logic [DW-1:0]    line_data, rob_data;

  // Acceptance: one tag lookup per texel.
  assign in_ready = !q_full && (lk_hit || (lk_pend_zero && free_any));
  assign accept   = in_valid && in_ready;
  assign alloc    = accept && !lk_hit;
  assign share    = accept && lk_hit && lk_infl;

  always_comb begin
    new_ent.payload = in_payload;
    new_ent.last    = in_last;
    new_ent.hit     = lk_hit;
    new_ent.src     = (!lk_hit || lk_infl) ? SRC_SLOT : SRC_LINE;
    new_ent.idx     = in_addr[IW-1:0];
    new_ent.slot    = lk_hit ? lk_islot : free_slot;
  end

  assign mem_req_valid = alloc;
  assign mem_req_addr  = in_addr;
  assign mem_req_slot  = free_slot;

  // Retirement from the queue head.
  assign head         = ent_t'(head_bits);
  assign out_valid    = !q_empty && ((head.src == SRC_LINE) || slot_ready[head.slot]);
  assign ret          = out_valid && out_ready;
  assign ret_slot_use = ret && (head.src == SRC_SLOT);
  assign out_data     = (head.src == SRC_SLOT) ? rob_data : line_data;
  assign out_payload  = head.payload;
  assign out_last     = head.last;
  assign out_hit      = head.hit;

  tpq_tags #(.LINES(LINES), .TW(TW), .DW(DW), .SW(SW), .CW(CW)) u_tags (
    .clk(clk), .rst_n(core_rst_n),
    .lk_idx(in_addr[IW-1:0]), .lk_tag(in_addr[AW-1:IW]),
    .acc(accept), .alloc(alloc), .alloc_slot(free_slot),
    .ret(ret), .ret_idx(head.idx), .ret_commit(ret_slot_use),
    .ret_slot(head.slot), .commit_data(rob_data),
    .lk_hit(lk_hit), .lk_infl(lk_infl), .lk_islot(lk_islot),
    .lk_pend_zero(lk_pend_zero), .rd_data(line_data)
  );

  tpq_rob #(.SLOTS(SLOTS), .DW(DW), .CW(CW)) u_rob (
    .clk(clk), .rst_n(core_rst_n),
    .alloc(alloc), .share(share), .share_slot(lk_islot),
    .rel(ret_slot_use), .rel_slot(head.slot),
    .rsp_valid(mem_rsp_valid), .rsp_slot(mem_rsp_slot), .rsp_data(mem_rsp_data),
    .rd_slot(head.slot), .free_any(free_any), .free_slot(free_slot),
    .busy(slot_busy), .ready(slot_ready), .rd_data(rob_data)
  );

  tpq_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(core_rst_n),
    .push(accept), .din(new_ent), .pop(ret), .dout(head_bits),
    .full(q_full), .empty(q_empty), .count(q_count)
  );
endmodule

// File: rtl/texel_prefetch_queue_chk.sv
module texel_prefetch_queue_chk #(
  parameter int SLOTS  = 4,
  parameter int QDEPTH = 8,
  parameter int DW     = 16,
  parameter int PW     = 8,
  parameter int SW     = 2,
  parameter int CW     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             mem_req_valid,
  input logic [SW-1:0]    mem_req_slot,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic [PW-1:0]    out_payload,
  input logic             out_last,
  input logic [SLOTS-1:0] slot_busy,
  input logic             free_any,
  input logic             lk_hit,
  input logic [CW-1:0]    q_count
);
  AST_REQ_IN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (in_valid && in_ready)); // R3
  AST_REQ_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !slot_busy[mem_req_slot]); // R3
  AST_NO_SLOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lk_hit && !free_any) |-> (!in_ready && !mem_req_valid)); // R4
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(QDEPTH)); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CW'(QDEPTH)) |-> !in_ready); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_payload) && $stable(out_last))); // R8
endmodule

bind texel_prefetch_queue texel_prefetch_queue_chk #(
  .SLOTS(SLOTS), .QDEPTH(QDEPTH), .DW(DW), .PW(PW), .SW(SW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(core_rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .mem_req_valid(mem_req_valid), .mem_req_slot(mem_req_slot),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_payload(out_payload), .out_last(out_last),
  .slot_busy(slot_busy), .free_any(free_any), .lk_hit(lk_hit), .q_count(q_count)
);

// File: tb/texel_prefetch_queue_tb.sv
`timescale 1ns/1ps
module texel_prefetch_queue_tb;
  localparam int AW = 8, DW = 16, PW = 8, LINES = 8, SLOTS = 4, QDEPTH = 8;
  localparam int SW = 2;

  logic          clk, rst_n;
  logic          in_valid, in_ready, in_last;
  logic [AW-1:0] in_addr;
  logic [PW-1:0] in_payload;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic [SW-1:0] mem_req_slot;
  logic          mem_rsp_valid;
  logic [SW-1:0] mem_rsp_slot;
  logic [DW-1:0] mem_rsp_data;
  logic          out_valid, out_ready, out_last, out_hit;
  logic [DW-1:0] out_data;
  logic [PW-1:0] out_payload;

  texel_prefetch_queue #(.AW(AW), .DW(DW), .PW(PW), .LINES(LINES),
                         .SLOTS(SLOTS), .QDEPTH(QDEPTH)) u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit tmo = 0;

  // Stimulus stream and expected queue.
  logic [AW-1:0] s_addr [512];
  int s_len = 0, s_pos = 0;
  logic [AW-1:0] e_addr [512];
  logic [PW-1:0] e_pay  [512];
  logic          e_last [512];
  logic          e_hit  [512];
  int e_wr = 0, e_rd = 0;

  // Reference tag model and per-line reference counts.
  logic          mv [LINES];
  logic [4:0]    mt [LINES];
  int            pcnt [LINES];
  // Memory stub.
  logic          mact [SLOTS];
  logic [AW-1:0] maddr [SLOTS];
  int            mdly [SLOTS];
  bit pause = 0, rdy_all = 1;
  int nreq = 0, nmiss = 0;
  bit prev_stall = 0;
  logic [DW-1:0] prev_data;

  function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
    return {a, a ^ 8'h5A};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add(input logic [AW-1:0] a);
    s_addr[s_len] = a;
    s_len++;
  endtask

  function automatic bool_busy();
    bit b = 0;
    for (int s = 0; s < SLOTS; s++) if (mact[s]) b = 1;
    return b;
  endfunction

  task automatic cycle();
    bit found;
    int st;
    logic [2:0] ix;
    bit h;
    @(negedge clk);
    in_valid   = (s_pos < s_len);
    in_addr    = s_addr[s_pos % 512];
    in_payload = PW'(s_pos);
    in_last    = s_pos[0];
    out_ready  = rdy_all ? 1'b1 : ($urandom_range(0, 3) != 0);
    mem_rsp_valid = 1'b0;
    mem_rsp_slot  = '0;
    mem_rsp_data  = '0;
    found = 0;
    if (!pause && $urandom_range(0, 3) != 0) begin
      st = $urandom_range(0, SLOTS - 1);
      for (int k = 0; k < SLOTS; k++) begin
        int s = (st + k) % SLOTS;
        if (!found && mact[s] && mdly[s] == 0) begin
          found = 1;
          mem_rsp_valid = 1'b1;
          mem_rsp_slot  = SW'(s);
          mem_rsp_data  = fdat(maddr[s]);
        end
      end
    end
    #1;
    if (prev_stall) begin
      chk(out_valid && out_data == prev_data, "R8 output held", {out_valid, out_data}, {1'b1, prev_data});
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (mem_rsp_valid) mact[mem_rsp_slot] = 1'b0;
    for (int s = 0; s < SLOTS; s++) if (mact[s] && mdly[s] > 0) mdly[s]--;
    if (in_valid && in_ready) begin
      ix = in_addr[2:0];
      h  = mv[ix] && (mt[ix] == in_addr[7:3]);
      chk(mem_req_valid == !h, "R2 single lookup decides request", mem_req_valid, !h);
      if (!h) begin
        chk(pcnt[ix] == 0, "R5 miss to referenced line", pcnt[ix], 0);
        mv[ix] = 1'b1;
        mt[ix] = in_addr[7:3];
        nmiss++;
      end
      pcnt[ix]++;
      e_addr[e_wr % 512] = in_addr;
      e_pay[e_wr % 512]  = in_payload;
      e_last[e_wr % 512] = in_last;
      e_hit[e_wr % 512]  = h;
      e_wr++;
      s_pos++;
    end
    if (mem_req_valid) begin
      nreq++;
      chk(!mact[mem_req_slot], "R3 request to idle slot", mact[mem_req_slot], 0);
      chk(mem_req_addr == in_addr, "R3 request address", mem_req_addr, in_addr);
      mact[mem_req_slot]  = 1'b1;
      maddr[mem_req_slot] = mem_req_addr;
      mdly[mem_req_slot]  = $urandom_range(0, 12);
    end
    if (out_valid && out_ready) begin
      if (e_rd == e_wr) begin
        chk(0, "R7 unexpected output", out_payload, 0);
      end else begin
        int r = e_rd % 512;
        chk(out_data == fdat(e_addr[r]), e_hit[r] ? "R9 hit data" : "R7 miss data",
            out_data, fdat(e_addr[r]));
        chk(out_payload == e_pay[r] && out_last == e_last[r], "R7 order",
            {out_last, out_payload}, {e_last[r], e_pay[r]});
        chk(out_hit == e_hit[r], "R2 hit flag", out_hit, e_hit[r]);
        pcnt[e_addr[r][2:0]]--;
        e_rd++;
      end
    end
    cyc++;
    if (cyc > 100000 && !tmo) begin
      tmo = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    end
  endtask

  task automatic drain();
    while ((s_pos < s_len || e_rd != e_wr || bool_busy()) && !tmo) cycle();
  endtask

  initial begin
    int base;
    for (int l = 0; l < LINES; l++) begin mv[l] = 0; mt[l] = '0; pcnt[l] = 0; end
    for (int s = 0; s < SLOTS; s++) begin mact[s] = 0; maddr[s] = '0; mdly[s] = 0; end
    rst_n = 1'b0; in_valid = 0; in_addr = '0; in_payload = '0; in_last = 0;
    out_ready = 0; mem_rsp_valid = 0; mem_rsp_slot = '0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid", mem_req_valid, 0);

    // R4: five misses to distinct lines, memory held back.
    pause = 1; rdy_all = 1;
    for (int i = 0; i < 5; i++) add(AW'(i));
    repeat (12) cycle();
    chk(nreq == 4, "R4 requests with slots exhausted", nreq, 4);
    chk(in_valid && !in_ready, "R4 miss held off", in_ready, 0);
    chk(s_pos == 4, "R4 accepted texels", s_pos, 4);
    pause = 0;
    drain();

    // R6: one miss then hits on the same line until the queue fills.
    pause = 1;
    base = s_pos;
    for (int i = 0; i < 12; i++) add(8'h48);
    repeat (15) cycle();
    chk(s_pos - base == QDEPTH, "R6 queue depth", s_pos - base, QDEPTH);
    chk(!in_ready, "R6 full stall", in_ready, 0);
    pause = 0;
    drain();

    // Mixed patterns with random back-pressure and answer order.
    rdy_all = 0;
    for (int i = 0; i < 32; i++) add(AW'(i));
    for (int i = 0; i < 6; i++) add(8'h90);
    for (int i = 0; i < 8; i++) add(i[0] ? 8'h0B : 8'h03);
    for (int i = 0; i < 60; i++) add(AW'((i * 37) % 256));
    for (int i = 0; i < 24; i++) add(AW'((i % 3) * 8 + 5));
    drain();
    chk(nreq == nmiss, "R2 requests equal misses", nreq, nmiss);
    chk(e_rd == s_len, "R7 all texels retired", e_rd, s_len);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule